// File: doc/BRIEF.md
# Serial Receiver with Line Error Status

This block is the receive half of an asynchronous serial port. It watches the incoming line and waits for a falling edge. It confirms the start bit at mid-bit and then samples each data bit at its centre, least significant bit first. It also checks an optional parity bit and the first stop bit. When the frame is complete, the character is placed in a one-entry receive buffer and a set of status flags is updated. These flags cover buffer full, overrun, parity, framing and break, plus a live flag that shows a frame is being received.

Software or a neighbouring block sets the character format through static control inputs: word length, parity enable, even/odd select and stick parity. It also sets the bit timing, either 16 samples per bit with a divisor-driven sample clock, or divide-by-one, where one bit lasts exactly a divisor's worth of clocks. A read strobe takes the character. The sticky error flags are cleared by writing ones to their positions.

Top module: `uart_rx_stat`

## Requirements
- R1: After reset, `status_o` reads 0 and `rx_data_o` reads 0.
- R2: A frame consists of a low start bit, then 5 + `word_len_i` data bits least significant first (code 0..3 gives 5..8 bits), then an optional parity bit and a stop bit. When the frame completes, the data appears zero-extended on `rx_data_o` and status bit 0 (ready) sets.
- R3: A one-cycle `rd_buf_i` pulse clears status bit 0. `rx_data_o` keeps its value.
- R4: If a frame completes while bit 0 is still set and no read is in that cycle, status bit 1 (overrun) sets. The new character is discarded, and `rx_data_o` and bit 0 keep their values.
- R5: With `par_en_i` high, one parity bit follows the data. Its expected value is as follows. With `par_stick_i` high, it is 0 when `par_even_i` is 1 and 1 when `par_even_i` is 0. Otherwise it is the XOR of the data bits when `par_even_i` is 1, and its inverse when `par_even_i` is 0. A mismatch sets status bit 2.
- R6: If the first stop-bit sample is low and the frame is not a break, status bit 3 (framing) sets.
- R7: If every sample of a frame, the stop sample included, is low, status bit 4 (break) sets and the character stored is 0. Bits 2 and 3 are not set by that frame. A new start bit is only looked for after the line returns high.
- R8: A low pulse on the line that has ended by the mid-point of the start bit is ignored. No character is stored and the status stays unchanged.
- R9: Status bit 11 is high from the start edge until the stop sample. It is low while the line is idle.
- R10: A write with `stat_wr_i` clears each of status bits 1..4 whose `stat_w1c_i` bit is 1; `stat_w1c_i` = 4'hF clears all four. Bits at 0 have no effect, and bit 0 is never changed by a write.
- R11: In 16x mode (`div_one_i` = 0), a bit lasts 16 × `divisor_i` clocks. In divide-by-one mode (`div_one_i` = 1), a bit lasts `divisor_i` clocks (`divisor_i` ≥ 2). In both modes the receiver samples at mid-bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Serial receive line, idle high |
| word_len_i | input | 2 | Data bits minus 5 |
| par_en_i | input | 1 | Parity bit present |
| par_even_i | input | 1 | Even parity select |
| par_stick_i | input | 1 | Stick (constant) parity |
| div_one_i | input | 1 | 1 = divide-by-one timing, 0 = 16x oversampling |
| divisor_i | input | 16 | Bit-timing divisor |
| rd_buf_i | input | 1 | Read strobe for the receive buffer |
| stat_wr_i | input | 1 | Status write strobe |
| stat_w1c_i | input | 4 | Write-one-to-clear mask for status bits 4..1 |
| rx_data_o | output | 8 | Receive buffer |
| status_o | output | 12 | Status: 0 ready, 1 overrun, 2 parity, 3 framing, 4 break, 11 receiving |

## Verification
The embedded assertions check the following on every cycle:
- a read drops the ready flag;
- an overrun leaves the buffer untouched;
- a break never raises the parity or framing flags together with itself;
- ready only rises right after a frame was in progress;
- the data bit counter stays in range.

Only the bench scenarios can show the rest:
- whether the character value is correct for each word length and timing mode;
- the parity rules, including stick parity;
- glitch rejection;
- waiting for the line to return high after a break;
- the selective write-one-to-clear behaviour.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
    localparam int DATA_W = 8;
    localparam int STAT_W = 12;
    localparam int OVS    = 16;

    localparam int ST_RDY  = 0;
    localparam int ST_OVR  = 1;
    localparam int ST_PAR  = 2;
    localparam int ST_FRM  = 3;
    localparam int ST_BRK  = 4;
    localparam int ST_BUSY = 11;

    typedef enum logic [2:0] {
        S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_WAIT
    } rx_state_e;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = {sr_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '1;
        else        sr_q <= sr_d;
    end

    assign dout = sr_q[STAGES-1];
endmodule

// File: rtl/rx_tick.sv
module rx_tick #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             div_one,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    logic [DIV_W-1:0] pc_d, pc_q;
    logic [DIV_W-1:0] tdiv;

    always_comb begin
        if (div_one || divisor == '0) tdiv = DIV_W'(1);
        else                          tdiv = divisor;
        tick = 1'b0;
        pc_d = pc_q + 1'b1;
        if (restart) begin
            pc_d = '0;
        end else if (pc_q >= tdiv - 1'b1) begin
            tick = 1'b1;
            pc_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
    end
endmodule

// File: rtl/rx_frame.sv
module rx_frame
    import uart_rx_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx,
    input  logic              tick,
    input  logic [1:0]        word_len,
    input  logic              par_en,
    input  logic              par_even,
    input  logic              par_stick,
    input  logic              div_one,
    input  logic [DIV_W-1:0]  divisor,
    output logic              restart,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] data,
    output logic              perr,
    output logic              ferr,
    output logic              brk
);
    typedef struct packed {
        rx_state_e        st;
        logic [DIV_W-1:0] cnt;
        logic [3:0]       bitn;
        logic [DATA_W-1:0] shreg;
        logic             par;
        logic             zeros;
        logic             perr;
    } frame_t;

    frame_t d, q;
    logic [DIV_W-1:0] len, half;
    logic [3:0]       nbits;
    logic             at_end, exp_par;

    always_comb begin
        len     = div_one ? divisor : DIV_W'(OVS);
        half    = len >> 1;
        nbits   = 4'd5 + {2'b00, word_len};
        at_end  = tick && (q.cnt == len - 1'b1);
        exp_par = par_stick ? ~par_even : (par_even ? q.par : ~q.par);
        d       = q;
        restart = 1'b0;
        done    = 1'b0;
        case (q.st)
            S_IDLE: if (!rx) begin
                d.st    = S_START;
                d.cnt   = '0;
                restart = 1'b1;
            end
            S_START: if (tick) begin
                if (q.cnt == half - 1'b1) begin
                    d.cnt = '0;
                    if (!rx) begin
                        d.st    = S_DATA;
                        d.bitn  = '0;
                        d.par   = 1'b0;
                        d.zeros = 1'b1;
                        d.perr  = 1'b0;
                    end else begin
                        d.st = S_IDLE;
                    end
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            S_DATA: if (at_end) begin
                d.shreg = {rx, q.shreg[DATA_W-1:1]};
                d.par   = q.par ^ rx;
                d.zeros = q.zeros & ~rx;
                d.cnt   = '0;
                d.bitn  = q.bitn + 1'b1;
                if (q.bitn == nbits - 1'b1) d.st = par_en ? S_PAR : S_STOP;
            end else if (tick) begin
                d.cnt = q.cnt + 1'b1;
            end
            S_PAR: if (at_end) begin
                d.perr  = (rx != exp_par);
                d.zeros = q.zeros & ~rx;
                d.cnt   = '0;
                d.st    = S_STOP;
            end else if (tick) begin
                d.cnt = q.cnt + 1'b1;
            end
            S_STOP: if (at_end) begin
                done = 1'b1;
                d.st = rx ? S_IDLE : S_WAIT;
            end else if (tick) begin
                d.cnt = q.cnt + 1'b1;
            end
            S_WAIT: if (rx) d.st = S_IDLE;
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: S_IDLE, default: '0};
        else        q <= d;
    end

    assign busy = (q.st == S_START) || (q.st == S_DATA) ||
                  (q.st == S_PAR)   || (q.st == S_STOP);
    assign brk  = q.zeros & ~rx;
    assign ferr = ~rx & ~q.zeros;
    assign perr = q.perr & ~brk;
    assign data = q.shreg >> (4'(DATA_W) - nbits);

    // R2
    no_bitcnt_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_DATA) |-> (q.bitn < 4'(DATA_W)));
endmodule

// File: rtl/uart_rx_stat.sv
module uart_rx_stat
    import uart_rx_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_i,
    input  logic [1:0]        word_len_i,
    input  logic              par_en_i,
    input  logic              par_even_i,
    input  logic              par_stick_i,
    input  logic              div_one_i,
    input  logic [DIV_W-1:0]  divisor_i,
    input  logic              rd_buf_i,
    input  logic              stat_wr_i,
    input  logic [4:1]        stat_w1c_i,
    output logic [DATA_W-1:0] rx_data_o,
    output logic [STAT_W-1:0] status_o
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic rdy, ovr, par, frm, brk;
    } buf_t;

    buf_t d, q;
    logic rx_s, tick, restart, busy, f_done, f_perr, f_ferr, f_brk, rdy_eff;
    logic [DATA_W-1:0] f_data;

    rx_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(rx_i), .dout(rx_s));

    rx_tick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .div_one(div_one_i), .divisor(divisor_i), .tick(tick));

    rx_frame #(.DIV_W(DIV_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .rx(rx_s), .tick(tick),
        .word_len(word_len_i), .par_en(par_en_i), .par_even(par_even_i),
        .par_stick(par_stick_i), .div_one(div_one_i), .divisor(divisor_i),
        .restart(restart), .busy(busy), .done(f_done), .data(f_data),
        .perr(f_perr), .ferr(f_ferr), .brk(f_brk));

    always_comb begin
        d       = q;
        rdy_eff = q.rdy & ~rd_buf_i;
        d.rdy   = rdy_eff;
        if (stat_wr_i) begin
            if (stat_w1c_i[ST_OVR]) d.ovr = 1'b0;
            if (stat_w1c_i[ST_PAR]) d.par = 1'b0;
            if (stat_w1c_i[ST_FRM]) d.frm = 1'b0;
            if (stat_w1c_i[ST_BRK]) d.brk = 1'b0;
        end
        if (f_done) begin
            if (rdy_eff) begin
                d.ovr = 1'b1;
            end else begin
                d.data = f_data;
                d.rdy  = 1'b1;
                d.par  = d.par | f_perr;
                d.frm  = d.frm | f_ferr;
                d.brk  = d.brk | f_brk;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        status_o          = '0;
        status_o[ST_RDY]  = q.rdy;
        status_o[ST_OVR]  = q.ovr;
        status_o[ST_PAR]  = q.par;
        status_o[ST_FRM]  = q.frm;
        status_o[ST_BRK]  = q.brk;
        status_o[ST_BUSY] = busy;
    end
    assign rx_data_o = q.data;

    // R3
    rd_clears_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_buf_i && !f_done) |=> !q.rdy);
    // R4
    overrun_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.ovr) |-> ($stable(q.data) && q.rdy));
    // R7
    break_masks_errs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.brk) |-> (!$rose(q.par) && !$rose(q.frm)));
    // R9
    ready_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.rdy) |-> $past(busy));
endmodule

// File: tb/sim_uart_rx_stat.sv
module sim_uart_rx_stat;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_i = 1'b1;
    logic [1:0] word_len_i = 2'd3;
    logic par_en_i = 1'b0, par_even_i = 1'b0, par_stick_i = 1'b0, div_one_i = 1'b0;
    logic [15:0] divisor_i = 16'd2;
    logic rd_buf_i = 1'b0, stat_wr_i = 1'b0;
    logic [4:1] stat_w1c_i = 4'h0;
    logic [7:0] rx_data_o;
    logic [11:0] status_o;
    int checks = 0, errors = 0;
    bit done_flag = 1'b0;

    always #5 clk = ~clk;

    uart_rx_stat u0 (
        .clk(clk), .rst_n(rst_n), .rx_i(rx_i), .word_len_i(word_len_i),
        .par_en_i(par_en_i), .par_even_i(par_even_i), .par_stick_i(par_stick_i),
        .div_one_i(div_one_i), .divisor_i(divisor_i), .rd_buf_i(rd_buf_i),
        .stat_wr_i(stat_wr_i), .stat_w1c_i(stat_w1c_i),
        .rx_data_o(rx_data_o), .status_o(status_o));

    // [23:22] wl [21] pen [20] peven [19] stick [18] div1 [17:10] divisor
    // [9:2] data [1] corrupt parity [0] low stop bit
    localparam logic [23:0] VEC [7] = '{
        {2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 8'd2,  8'hA5, 1'b0, 1'b0},
        {2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 8'd10, 8'h13, 1'b0, 1'b0},
        {2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 8'd1,  8'h55, 1'b0, 1'b0},
        {2'd3, 1'b1, 1'b1, 1'b1, 1'b1, 8'd8,  8'hC3, 1'b0, 1'b0},
        {2'd3, 1'b1, 1'b1, 1'b0, 1'b1, 8'd12, 8'h3C, 1'b1, 1'b0},
        {2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd2,  8'h2A, 1'b0, 1'b1},
        {2'd3, 1'b1, 1'b0, 1'b1, 1'b0, 8'd1,  8'h81, 1'b1, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic send(input logic [7:0] d, input int nb, input logic pen,
                        input logic pbit, input logic stopv, input int bclk,
                        input logic chk_ro);
        rx_i = 1'b0;
        repeat (bclk) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            rx_i = d[i];
            repeat (bclk / 2) @(negedge clk);
            if (chk_ro && i == 2) chk("R9 receiving flag mid-frame", 32'(status_o[11]), 1);
            repeat (bclk - bclk / 2) @(negedge clk);
        end
        if (pen) begin
            rx_i = pbit;
            repeat (bclk) @(negedge clk);
        end
        rx_i = stopv;
        repeat (bclk) @(negedge clk);
        rx_i = 1'b1;
        repeat (2 * bclk) @(negedge clk);
    endtask

    task automatic rd_clear();
        rd_buf_i = 1'b1; stat_wr_i = 1'b1; stat_w1c_i = 4'hF;
        @(negedge clk);
        rd_buf_i = 1'b0; stat_wr_i = 1'b0; stat_w1c_i = 4'h0;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got hang expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        chk("R1 status after reset", 32'(status_o), 0);
        chk("R1 data after reset", 32'(rx_data_o), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R9 idle receiving flag", 32'(status_o[11]), 0);

        // table walk: R2 R5 R6 R11
        for (int i = 0; i < 7; i++) begin
            logic [23:0] v;
            int nb, bclk;
            logic [7:0] dm;
            logic pb;
            v = VEC[i];
            word_len_i = v[23:22]; par_en_i = v[21]; par_even_i = v[20];
            par_stick_i = v[19]; div_one_i = v[18]; divisor_i = {8'd0, v[17:10]};
            nb = 5 + int'(v[23:22]);
            bclk = v[18] ? int'(v[17:10]) : 16 * int'(v[17:10]);
            dm = v[9:2] & 8'((1 << nb) - 1);
            if (v[19]) pb = ~v[20];
            else pb = v[20] ? ^dm : ~^dm;
            pb = pb ^ v[1];
            @(negedge clk);
            send(v[9:2], nb, v[21], pb, ~v[0], bclk, (i == 0));
            chk($sformatf("R2 R11 vector %0d data", i), 32'(rx_data_o), 32'(dm));
            chk($sformatf("R5 R6 vector %0d status", i), 32'(status_o),
                32'(1 | (v[1] ? 4 : 0) | (v[0] ? 8 : 0)));
            rd_clear();
            chk($sformatf("R3 R10 vector %0d cleared", i), 32'(status_o), 0);
        end

        word_len_i = 2'd3; par_en_i = 1'b0; par_stick_i = 1'b0;
        div_one_i = 1'b0; divisor_i = 16'd2;
        @(negedge clk);

        // R8 glitch rejection
        rx_i = 1'b0;
        repeat (8) @(negedge clk);
        rx_i = 1'b1;
        repeat (64) @(negedge clk);
        chk("R8 glitch ignored status", 32'(status_o), 0);

        // R4 overrun, R10 selective clear, R3 read
        send(8'h5A, 8, 1'b0, 1'b0, 1'b1, 32, 1'b0);
        send(8'hA7, 8, 1'b0, 1'b0, 1'b1, 32, 1'b0);
        chk("R4 overrun data kept", 32'(rx_data_o), 32'h5A);
        chk("R4 overrun status", 32'(status_o), 32'h003);
        stat_wr_i = 1'b1; stat_w1c_i = 4'h0;
        @(negedge clk);
        stat_wr_i = 1'b0;
        @(negedge clk);
        chk("R10 zero mask no effect", 32'(status_o), 32'h003);
        stat_wr_i = 1'b1; stat_w1c_i = 4'b0001;
        @(negedge clk);
        stat_wr_i = 1'b0; stat_w1c_i = 4'h0;
        @(negedge clk);
        chk("R10 clear overrun only", 32'(status_o), 32'h001);
        rd_buf_i = 1'b1;
        @(negedge clk);
        rd_buf_i = 1'b0;
        @(negedge clk);
        chk("R3 read clears ready", 32'(status_o), 0);
        chk("R3 data stays", 32'(rx_data_o), 32'h5A);

        // R7 break with parity enabled
        par_en_i = 1'b1; par_even_i = 1'b1;
        @(negedge clk);
        rx_i = 1'b0;
        repeat (32 * 14) @(negedge clk);
        chk("R7 waiting for line high", 32'(status_o[11]), 0);
        rx_i = 1'b1;
        repeat (64) @(negedge clk);
        chk("R7 break status", 32'(status_o), 32'h011);
        chk("R7 break data", 32'(rx_data_o), 0);
        rd_clear();
        send(8'h96, 8, 1'b1, ^8'h96, 1'b1, 32, 1'b0);
        chk("R7 frame after break data", 32'(rx_data_o), 32'h96);
        chk("R7 frame after break status", 32'(status_o), 32'h001);

        done_flag = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule